// File: doc/BRIEF.md
# Interrupt Vector Delivery Unit

This unit sits between a set of device interrupt lines and one processor core and hands the core a single vectored interrupt at a time. Up to 64 direct vector lines and 16 legacy bus interrupt lines feed it. A small fixed routing table folds five of the legacy lines onto vector numbers. The remaining legacy lines are unrouted and are dropped. When a vector line rises and no delivery is outstanding, the unit claims its single delivery slot. It then records a description of the source in three data words, raises an interrupt request carrying the vector trap type, and pulses a wake signal so that a halted core resumes.

The slot stays claimed until the line that was captured falls, or until the clear input is asserted. The clear input stands in for the software read-and-clear of the data words. Rising lines that arrive while the slot is claimed are not queued. The unit reacts only to edges, so a line that stays high through a delivery is not picked up afterwards. When several lines rise in the same cycle, the lowest-numbered one wins.

Top module: `intvec_deliver`

## Requirements
- R1: After reset, busy, request and wake are 0, the trap type output is 0 and all three data words are 0.
- R2: A vector line that is low in one cycle and high in the next, while busy is 0, sets busy and the request in the cycle after it is sampled high. The trap type output reads 0x060 whenever the request is high and 0 otherwise.
- R3: On a capture, data word 0 becomes 0x7C0 OR the vector number. That places 5'b11111 in bits 10:6, the vector in bits 5:0 and zeros in every other bit. Data words 1 and 2 become zero.
- R4: A vector rising while busy is 1 is ignored: busy stays 1 and data word 0 keeps the earlier value.
- R5: When the captured line is sampled low while busy, busy and the request fall in the next cycle. A different line falling leaves busy at 1.
- R6: Each capture produces a wake pulse that is high for exactly the one cycle in which busy first reads 1.
- R7: Legacy line 1 acts as vector 0x29, line 4 as 0x2B, line 6 as 0x27, line 7 as 0x22 and line 12 as 0x2A.
- R8: Legacy lines 0, 2, 3, 5, 8 to 11 and 13 to 15 have no effect: busy stays 0.
- R9: When several vector lines rise in the same cycle, the lowest-numbered one is captured.
- R10: The clear input, sampled high while busy, drops busy and the request in the next cycle. The data words keep their values.
- R11: Only rising edges capture. A line that is still high when busy falls is captured only after it goes low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| leg_irq_i | input | 16 | Legacy bus interrupt lines |
| vec_irq_i | input | 64 | Direct vector interrupt lines |
| clr_i | input | 1 | Releases the delivery slot |
| busy_o | output | 1 | Delivery slot claimed |
| irq_req_o | output | 1 | Interrupt request to the core |
| trap_type_o | output | 9 | Trap type of the pending request |
| wake_o | output | 1 | One-cycle wake pulse for a halted core |
| data0_o | output | 64 | Source descriptor word 0 |
| data1_o | output | 64 | Source descriptor word 1 |
| data2_o | output | 64 | Source descriptor word 2 |

## Verification
The bench builds the block with its default parameters: 64 vector lines and 16 legacy lines. With these values every entry of the routing table is reachable, as is every unrouted legacy line. Vector 0 and vector 63 exercise both ends of the lowest-number pick and the full 6-bit field of data word 0. Simultaneous rises, a rise while busy, a release by clear, and a line still held high when the slot frees are all driven. A behavioural model checks every output on every clock.

// File: rtl/intvec_pkg.sv
package intvec_pkg;

  localparam int DATA_W      = 64;
  localparam int VFIELD_W    = 6;
  localparam int TRAP_W      = 9;
  localparam int SRC_LSB     = 6;
  localparam logic [TRAP_W-1:0] TRAP_VECTOR = 9'h060;
  localparam logic [4:0]        SRC_FIELD   = 5'h1F;

  typedef struct packed {
    logic                valid;
    logic [VFIELD_W-1:0] vec;
  } leg_route_t;

  // Routing of legacy bus lines onto vector numbers.
  function automatic leg_route_t leg_route(input int unsigned line);
    leg_route_t r;
    r = '0;
    case (line)
      7:  r = '{valid: 1'b1, vec: 6'h22};
      6:  r = '{valid: 1'b1, vec: 6'h27};
      1:  r = '{valid: 1'b1, vec: 6'h29};
      12: r = '{valid: 1'b1, vec: 6'h2A};
      4:  r = '{valid: 1'b1, vec: 6'h2B};
      default: r = '0;
    endcase
    return r;
  endfunction

  // Descriptor word 0: source field above the vector number.
  function automatic logic [DATA_W-1:0] pack_word0(input logic [VFIELD_W-1:0] vec);
    logic [DATA_W-1:0] w;
    w = '0;
    w[SRC_LSB +: 5]    = SRC_FIELD;
    w[VFIELD_W-1:0]    = vec;
    return w;
  endfunction

endpackage

// File: rtl/intvec_legacy_map.sv
module intvec_legacy_map #(
  parameter int NUM_LEG = 16,
  parameter int NUM_VEC = 64
) (
  input  logic [NUM_LEG-1:0] leg_i,
  output logic [NUM_VEC-1:0] routed_o
);
  import intvec_pkg::*;

  logic [NUM_VEC-1:0] contrib [NUM_LEG];

  for (genvar gl = 0; gl < NUM_LEG; gl++) begin : g_line
    localparam leg_route_t RT = leg_route(gl);
    if (RT.valid && (int'(RT.vec) < NUM_VEC)) begin : g_hit
      localparam logic [NUM_VEC-1:0] ONE_HOT = {{(NUM_VEC-1){1'b0}}, 1'b1} << RT.vec;
      assign contrib[gl] = leg_i[gl] ? ONE_HOT : '0;
    end else begin : g_drop
      assign contrib[gl] = '0;
    end
  end

  always_comb begin
    routed_o = '0;
    for (int l = 0; l < NUM_LEG; l++) routed_o = routed_o | contrib[l];
  end

endmodule

// File: rtl/intvec_edge_pick.sv
module intvec_edge_pick #(
  parameter int NUM_VEC = 64,
  localparam int VEC_W  = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] lines_i,
  output logic               rise_any_o,
  output logic [VEC_W-1:0]   rise_idx_o
);

  logic [NUM_VEC-1:0] prev_q;
  logic [NUM_VEC-1:0] rise;

  function automatic logic [VEC_W-1:0] lowest(input logic [NUM_VEC-1:0] b);
    logic [VEC_W-1:0] k;
    k = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) if (b[i]) k = VEC_W'(i);
    return k;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lines_i;
  end

  assign rise       = lines_i & ~prev_q;
  assign rise_any_o = |rise;
  assign rise_idx_o = lowest(rise);

endmodule

// File: rtl/intvec_slot.sv
module intvec_slot #(
  parameter int NUM_VEC = 64,
  localparam int VEC_W  = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_VEC-1:0]             lines_i,
  input  logic                           rise_any_i,
  input  logic [VEC_W-1:0]               rise_idx_i,
  input  logic                           clr_i,
  output logic                           busy_o,
  output logic                           wake_o,
  output logic                           cap_line_hi_o,
  output logic [intvec_pkg::DATA_W-1:0]  data0_o,
  output logic [intvec_pkg::DATA_W-1:0]  data1_o,
  output logic [intvec_pkg::DATA_W-1:0]  data2_o
);
  import intvec_pkg::*;

  logic             busy_q;
  logic             wake_q;
  logic [VEC_W-1:0] idx_q;
  logic [DATA_W-1:0] d0_q, d1_q, d2_q;

  assign cap_line_hi_o = lines_i[idx_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wake_q <= 1'b0;
      idx_q  <= '0;
      d0_q   <= '0;
      d1_q   <= '0;
      d2_q   <= '0;
    end else begin
      wake_q <= 1'b0;
      if (busy_q) begin
        if (clr_i || !cap_line_hi_o) busy_q <= 1'b0;
      end else if (rise_any_i) begin
        busy_q <= 1'b1;
        wake_q <= 1'b1;
        idx_q  <= rise_idx_i;
        d0_q   <= pack_word0(VFIELD_W'(rise_idx_i));
        d1_q   <= '0;
        d2_q   <= '0;
      end
    end
  end

  assign busy_o  = busy_q;
  assign wake_o  = wake_q;
  assign data0_o = d0_q;
  assign data1_o = d1_q;
  assign data2_o = d2_q;

endmodule

// File: rtl/intvec_deliver.sv
module intvec_deliver #(
  parameter int NUM_LEG = 16,
  parameter int NUM_VEC = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_LEG-1:0]            leg_irq_i,
  input  logic [NUM_VEC-1:0]            vec_irq_i,
  input  logic                          clr_i,
  output logic                          busy_o,
  output logic                          irq_req_o,
  output logic [intvec_pkg::TRAP_W-1:0] trap_type_o,
  output logic                          wake_o,
  output logic [intvec_pkg::DATA_W-1:0] data0_o,
  output logic [intvec_pkg::DATA_W-1:0] data1_o,
  output logic [intvec_pkg::DATA_W-1:0] data2_o
);
  import intvec_pkg::*;

  localparam int VEC_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

  logic [NUM_VEC-1:0] leg_routed;
  logic [NUM_VEC-1:0] lines;
  logic               rise_any;
  logic [VEC_W-1:0]   rise_idx;
  logic               cap_line_hi;
  logic               busy;

  intvec_legacy_map #(.NUM_LEG(NUM_LEG), .NUM_VEC(NUM_VEC)) u_map (
    .leg_i    (leg_irq_i),
    .routed_o (leg_routed)
  );

  assign lines = vec_irq_i | leg_routed;

  intvec_edge_pick #(.NUM_VEC(NUM_VEC)) u_pick (
    .clk        (clk),
    .rst_n      (rst_n),
    .lines_i    (lines),
    .rise_any_o (rise_any),
    .rise_idx_o (rise_idx)
  );

  intvec_slot #(.NUM_VEC(NUM_VEC)) u_slot (
    .clk           (clk),
    .rst_n         (rst_n),
    .lines_i       (lines),
    .rise_any_i    (rise_any),
    .rise_idx_i    (rise_idx),
    .clr_i         (clr_i),
    .busy_o        (busy),
    .wake_o        (wake_o),
    .cap_line_hi_o (cap_line_hi),
    .data0_o       (data0_o),
    .data1_o       (data1_o),
    .data2_o       (data2_o)
  );

  assign busy_o      = busy;
  assign irq_req_o   = busy;
  assign trap_type_o = busy ? TRAP_VECTOR : '0;

endmodule

// File: rtl/intvec_checker.sv
module intvec_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        clr_i,
  input logic        busy_o,
  input logic        irq_req_o,
  input logic [8:0]  trap_type_o,
  input logic        wake_o,
  input logic [63:0] data0_o,
  input logic [63:0] data1_o,
  input logic [63:0] data2_o,
  input logic        rise_any,
  input logic        cap_line_hi
);

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_any && !busy_o) |=> (busy_o && irq_req_o));

  assert_trap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> (trap_type_o == 9'h060));

  assert_field_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (data0_o[10:6] == 5'h1F && data0_o[63:11] == '0));

  assert_zero_words_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (data1_o == '0 && data2_o == '0));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && cap_line_hi && !clr_i) |=> (busy_o && $stable(data0_o)));

  assert_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !cap_line_hi) |=> !busy_o);

  assert_wake_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> wake_o);

  assert_wake_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> !wake_o);

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && clr_i) |=> (!busy_o && $stable(data0_o)));

endmodule

bind intvec_deliver intvec_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .clr_i       (clr_i),
  .busy_o      (busy_o),
  .irq_req_o   (irq_req_o),
  .trap_type_o (trap_type_o),
  .wake_o      (wake_o),
  .data0_o     (data0_o),
  .data1_o     (data1_o),
  .data2_o     (data2_o),
  .rise_any    (rise_any),
  .cap_line_hi (cap_line_hi)
);

// File: tb/intvec_deliver_bench.sv
module intvec_deliver_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] leg = '0;
  logic [63:0] vec = '0;
  logic        clr = 1'b0;
  logic        busy, req, wake;
  logic [8:0]  trap;
  logic [63:0] d0, d1, d2;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  intvec_deliver u_intvec_deliver (
    .clk(clk), .rst_n(rst_n), .leg_irq_i(leg), .vec_irq_i(vec), .clr_i(clr),
    .busy_o(busy), .irq_req_o(req), .trap_type_o(trap), .wake_o(wake),
    .data0_o(d0), .data1_o(d1), .data2_o(d2)
  );

  // ---------------- behavioural reference ----------------
  bit [63:0] m_prev;
  bit        m_busy, m_wake;
  int        m_idx;
  bit [63:0] m_d0;

  function automatic bit [63:0] effective(bit [63:0] v, bit [15:0] l);
    bit [63:0] e = v;
    if (l[1])  e[41] = 1'b1;
    if (l[4])  e[43] = 1'b1;
    if (l[6])  e[39] = 1'b1;
    if (l[7])  e[34] = 1'b1;
    if (l[12]) e[42] = 1'b1;
    return e;
  endfunction

  always @(posedge clk) begin
    bit [63:0] e;
    int pick;
    if (!rst_n) begin
      m_prev = '0; m_busy = 0; m_wake = 0; m_idx = 0; m_d0 = '0;
    end else begin
      e = effective(vec, leg);
      m_wake = 0;
      if (m_busy) begin
        if (clr || !e[m_idx]) m_busy = 0;
      end else begin
        pick = -1;
        for (int i = 63; i >= 0; i--) if (e[i] && !m_prev[i]) pick = i;
        if (pick >= 0) begin
          m_busy = 1; m_wake = 1; m_idx = pick;
          m_d0 = 64'd1984 + 64'(pick);
        end
      end
      m_prev = e;
    end
  end

  task automatic chk(input string req_tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req_tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2", "busy/model", 64'(busy), 64'(m_busy));
      chk("R2", "req/model", 64'(req), 64'(m_busy));
      chk("R2", "trap/model", 64'(trap), m_busy ? 64'h60 : 64'h0);
      chk("R6", "wake/model", 64'(wake), 64'(m_wake));
      chk("R3", "data0/model", d0, m_d0);
      chk("R3", "data1/model", d1, 64'h0);
      chk("R3", "data2/model", d2, 64'h0);
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      #2;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unmapped[10] = '{0, 2, 3, 5, 8, 9, 10, 11, 13, 14};
    int lmap_line[5] = '{1, 4, 6, 7, 12};
    int lmap_vec[5]  = '{41, 43, 39, 34, 42};
    tick(3);
    // R1: reset state
    chk("R1", "busy", 64'(busy), 0);
    chk("R1", "req", 64'(req), 0);
    chk("R1", "wake", 64'(wake), 0);
    chk("R1", "trap", 64'(trap), 0);
    chk("R1", "data0", d0, 0);
    rst_n = 1'b1;
    tick(2);

    // R2 R3 R6: basic capture of vector 5
    vec[5] = 1'b1; tick();
    chk("R2", "busy after rise", 64'(busy), 1);
    chk("R2", "trap after rise", 64'(trap), 64'h60);
    chk("R3", "data0 vec5", d0, 64'h7C5);
    chk("R6", "wake pulse", 64'(wake), 1);
    tick();
    chk("R6", "wake single", 64'(wake), 0);

    // R4: second rise ignored
    vec[9] = 1'b1; tick(2);
    chk("R4", "data0 kept", d0, 64'h7C5);
    chk("R4", "busy kept", 64'(busy), 1);
    // R5: other line drop keeps busy, own drop clears
    vec[9] = 1'b0; tick(2);
    chk("R5", "other drop", 64'(busy), 1);
    vec[5] = 1'b0; tick();
    chk("R5", "own drop", 64'(busy), 0);
    chk("R5", "req after drop", 64'(req), 0);

    // R9: simultaneous rises
    vec[40] = 1'b1; vec[3] = 1'b1; vec[17] = 1'b1; tick();
    chk("R9", "lowest wins", d0, 64'h7C3);
    vec[3] = 1'b0; tick(3);
    // R11: lines 40/17 still high, no recapture
    chk("R11", "no level capture", 64'(busy), 0);
    vec = '0; tick();
    vec[40] = 1'b1; tick();
    chk("R11", "recapture after edge", d0, 64'h7E8);
    // R10: clear
    clr = 1'b1; tick(); clr = 1'b0;
    chk("R10", "clear busy", 64'(busy), 0);
    chk("R10", "clear keeps data", d0, 64'h7E8);
    vec = '0; tick(2);

    // R7: routed legacy lines
    for (int j = 0; j < 5; j++) begin
      leg[lmap_line[j]] = 1'b1; tick();
      chk("R7", $sformatf("legacy %0d", lmap_line[j]), d0, 64'h7C0 | 64'(lmap_vec[j]));
      chk("R7", "legacy busy", 64'(busy), 1);
      leg = '0; tick(2);
    end
    // R8: unrouted legacy lines
    for (int j = 0; j < 10; j++) begin
      leg[unmapped[j]] = 1'b1; tick(2);
      chk("R8", $sformatf("unrouted %0d", unmapped[j]), 64'(busy), 0);
      leg = '0; tick();
    end
    leg[15] = 1'b1; tick(2);
    chk("R8", "unrouted 15", 64'(busy), 0);
    leg = '0; tick();

    // boundaries: vector 63 and 0
    vec[63] = 1'b1; tick();
    chk("R3", "vec 63", d0, 64'h7FF);
    vec = '0; tick(2);
    vec[0] = 1'b1; vec[63] = 1'b1; tick();
    chk("R9", "vec 0 over 63", d0, 64'h7C0);
    vec = '0; tick(3);
    chk("R5", "idle at end", 64'(busy), 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule